// File: doc/BRIEF.md
# Programmable almost-full / almost-empty flag generator

This block drives the two programmable fill-level flags of a dual-clock FIFO, both active low: an almost-empty flag (`pae_n`) and an almost-full flag (`paf_n`). It takes the FIFO's binary write pointer (write clock domain) and read pointer (read clock domain). It passes each pointer to the opposite domain in Gray code through a two-stage synchronizer. Each domain then forms its own view of the stored word count and compares it with thresholds derived from an empty offset `n` and a full offset `m`.

Both offsets sit in registers that take a default value at reset, chosen by a three-bit reset-time code. When parallel loading was selected at reset, they can be rewritten afterwards through a write port clocked by `wclk`. They can always be read back in parallel. Two further reset-time straps pick the FIFO timing mode (standard or fall-through, which shifts every threshold by one word) and the flag timing. In synchronous timing each flag belongs to one clock. In asynchronous timing each flag is pulled active by one clock and released by the other.

All reset-time inputs are captured while `rst_n` is low and held until the next reset. The FIFO depth is D = 2^AW, and both pointers are AW+2 bits wide.

Top module: `almost_flags`

## Requirements
- R1: While `rst_n` is low, both offsets load the same default, chosen by code {cfg_ld, cfg_fsel[1], cfg_fsel[0]}: 000→127, 001→255, 010→511, 011→63, 100→1023, 101→15, 110→31, 111→7. Any default above D-1 is loaded as D-1.
- R2: `ofs_rdata` shows the empty offset when `ofs_rsel` is 0 and the full offset when it is 1, combinationally.
- R3: If `cfg_ld` was low at reset, a `wclk` edge with `ofs_we` high writes `ofs_wdata` into the empty offset (`ofs_sel`=0) or the full offset (`ofs_sel`=1). A value above D-1 is stored as D-1.
- R4: If `cfg_ld` was high at reset, the write port has no effect, and the flags keep using the reset defaults.
- R5: In standard mode (`cfg_fwft` low at reset), `pae_n` is high when the stored count is at least n+1 and low when it is n or less. The count is (wr_ptr − rd_ptr) modulo 2^(AW+2), so it stays correct across pointer wrap.
- R6: In fall-through mode (`cfg_fwft` high at reset), `pae_n` is high when the count is at least n+2 and low when it is n+1 or less.
- R7: `paf_n` is low when the count is at least D−m in standard mode, or at least D+1−m in fall-through mode, and high otherwise.
- R8: With `cfg_sync` high at reset, `paf_n` changes only on `wclk` edges and `pae_n` only on `rclk` edges. A write that crosses the empty threshold is therefore not yet visible on `pae_n` one `wclk` edge later, and a read that leaves the almost-full range is not yet visible on `paf_n` one `rclk` edge later.
- R9: With `cfg_sync` low at reset, `paf_n` goes low on the first `wclk` edge that sees the count at its threshold and returns high on the `rclk` edge whose read drops it below. `pae_n` goes low on the `rclk` edge whose read drops the count below its threshold and returns high on the first `wclk` edge whose write reaches it.
- R10: Right after reset, `pae_n` is low and `paf_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low; reset-time straps are captured while it is low |
| cfg_fwft | input | 1 | Reset strap: 1 selects fall-through timing mode |
| cfg_sync | input | 1 | Reset strap: 1 selects synchronous flag timing |
| cfg_ld | input | 1 | Reset strap: 1 selects serial loading (parallel writes ignored), also part of the default code |
| cfg_fsel | input | 2 | Reset strap: low two bits of the default offset code |
| wr_ptr | input | AW+2 | Binary write pointer, `wclk` domain |
| rd_ptr | input | AW+2 | Binary read pointer, `rclk` domain |
| ofs_we | input | 1 | Offset write strobe, `wclk` domain |
| ofs_sel | input | 1 | Offset write target: 0 empty, 1 full |
| ofs_wdata | input | AW+1 | Offset write value (values above D-1 saturate) |
| ofs_rsel | input | 1 | Offset readback select: 0 empty, 1 full |
| ofs_rdata | output | AW | Selected offset value |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions assume the following about the inputs:
- Both pointers are zero during reset.
- Each pointer changes only between edges of its own clock.
- The stored count never exceeds D+1.
- The straps are steady while `rst_n` is low, and at least one edge of each clock falls inside the reset pulse.

The stimulus meets these conditions in three ways:
- It moves `wr_ptr` only on falling `wclk` edges and `rd_ptr` only on falling `rclk` edges.
- It clears both pointers in every reset and holds reset for several cycles of both clocks.
- It keeps every fill level between 0 and D+1, taking pointer wrap in steps of equal writes and reads.

Steady-state flag values are checked only after both synchronizers have settled. The one-edge timing checks of R8 and R9 start from an already settled state.

// File: rtl/almost_flags.sv
`timescale 1ns/100ps
module almost_flags #(
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cfg_fwft,
  input  logic          cfg_sync,
  input  logic          cfg_ld,
  input  logic [1:0]    cfg_fsel,
  input  logic [AW+1:0] wr_ptr,
  input  logic [AW+1:0] rd_ptr,
  input  logic          ofs_we,
  input  logic          ofs_sel,
  input  logic [AW:0]   ofs_wdata,
  input  logic          ofs_rsel,
  output logic [AW-1:0] ofs_rdata,
  output logic          pae_n,
  output logic          paf_n
);
  localparam int PW = AW + 2;
  localparam int D  = 1 << AW;
  localparam logic [AW-1:0] TOP = AW'(D - 1);

  function automatic logic [AW-1:0] dflt(input logic [2:0] code);
    int v;
    case (code)
      3'b100:  v = 1023;
      3'b010:  v = 511;
      3'b001:  v = 255;
      3'b000:  v = 127;
      3'b011:  v = 63;
      3'b110:  v = 31;
      3'b101:  v = 15;
      default: v = 7;
    endcase
    return (v > D - 1) ? TOP : AW'(v);
  endfunction

  function automatic logic [AW-1:0] sat(input logic [AW:0] v);
    return v[AW] ? TOP : v[AW-1:0];
  endfunction

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // reset-time straps and offset registers
  logic          fwft_q, sync_q, serial_q;
  logic [AW-1:0] n_q, m_q;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      fwft_q   <= cfg_fwft;
      sync_q   <= cfg_sync;
      serial_q <= cfg_ld;
      n_q      <= dflt({cfg_ld, cfg_fsel});
      m_q      <= dflt({cfg_ld, cfg_fsel});
    end else if (ofs_we && !serial_q) begin
      if (ofs_sel) m_q <= sat(ofs_wdata);
      else         n_q <= sat(ofs_wdata);
    end

  assign ofs_rdata = ofs_rsel ? m_q : n_q;

  logic [PW-1:0] e_th, f_th;
  assign e_th = PW'(n_q) + PW'(1) + PW'(fwft_q);
  assign f_th = PW'(D) - PW'(m_q) + PW'(fwft_q);

  // pointer crossing
  logic [PW-1:0] wg_q, rg_q, wg_r1, wg_r2, rg_w1, rg_w2;
  logic [PW-1:0] wcount, rcount;
  assign wcount = wr_ptr - to_bin(rg_w2);
  assign rcount = to_bin(wg_r2) - rd_ptr;

  logic w_full, w_above, r_full, r_above;
  assign w_full  = wcount >= f_th;
  assign w_above = wcount >= e_th;
  assign r_full  = rcount >= f_th;
  assign r_above = rcount >= e_th;

  // flag state: sync registers and cross-clock toggle pairs
  logic       paf_sync_n, pae_sync_n;
  logic       paf_set_t, paf_clr_t, pae_set_t, pae_clr_t;
  logic [1:0] paf_clr_ws, pae_set_ws, paf_set_rs, pae_clr_rs;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wg_q       <= '0;
      rg_w1      <= '0;
      rg_w2      <= '0;
      paf_sync_n <= 1'b1;
      paf_set_t  <= 1'b0;
      pae_clr_t  <= 1'b0;
      paf_clr_ws <= 2'b00;
      pae_set_ws <= 2'b11;
    end else begin
      wg_q       <= to_gray(wr_ptr);
      rg_w1      <= rg_q;
      rg_w2      <= rg_w1;
      paf_clr_ws <= {paf_clr_ws[0], paf_clr_t};
      pae_set_ws <= {pae_set_ws[0], pae_set_t};
      paf_sync_n <= !w_full;
      if (paf_set_t == paf_clr_ws[1] && w_full)  paf_set_t <= !paf_set_t;
      if (pae_set_ws[1] != pae_clr_t && w_above) pae_clr_t <= !pae_clr_t;
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rg_q       <= '0;
      wg_r1      <= '0;
      wg_r2      <= '0;
      pae_sync_n <= 1'b0;
      pae_set_t  <= 1'b1;
      paf_clr_t  <= 1'b0;
      paf_set_rs <= 2'b00;
      pae_clr_rs <= 2'b00;
    end else begin
      rg_q       <= to_gray(rd_ptr);
      wg_r1      <= wg_q;
      wg_r2      <= wg_r1;
      paf_set_rs <= {paf_set_rs[0], paf_set_t};
      pae_clr_rs <= {pae_clr_rs[0], pae_clr_t};
      pae_sync_n <= r_above;
      if (pae_set_t == pae_clr_rs[1] && !r_above) pae_set_t <= !pae_set_t;
      if (paf_set_rs[1] != paf_clr_t && !r_full)  paf_clr_t <= !paf_clr_t;
    end

  assign paf_n = sync_q ? paf_sync_n : (paf_set_t == paf_clr_t);
  assign pae_n = sync_q ? pae_sync_n : (pae_set_t == pae_clr_t);

  assert_wsat_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (ofs_we && !serial_q && ofs_sel && ofs_wdata[AW]) |=> (m_q == TOP));

  assert_serial_hold_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    serial_q |=> ($stable(n_q) && $stable(m_q)));

  assert_paf_release_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    (!sync_q && $rose(paf_n)) |-> $past(rcount < f_th));

  assert_pae_fall_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    (!sync_q && $fell(pae_n)) |-> $past(rcount < e_th));
endmodule

// File: tb/sim_almost_flags.sv
`timescale 1ns/100ps
module sim_almost_flags;
  localparam int AW = 6;
  localparam int PW = AW + 2;
  localparam int D  = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          cfg_fwft = 1'b0, cfg_sync = 1'b0, cfg_ld = 1'b0;
  logic [1:0]    cfg_fsel = 2'b00;
  logic [PW-1:0] wr_ptr = '0, rd_ptr = '0;
  logic          ofs_we = 1'b0, ofs_sel = 1'b0, ofs_rsel = 1'b0;
  logic [AW:0]   ofs_wdata = '0;
  logic [AW-1:0] ofs_rdata;
  logic          pae_n, paf_n;
  int errors = 0, checks = 0;

  always #2.5 wclk = ~wclk;   // 200 MHz
  always #3.5 rclk = ~rclk;

  almost_flags #(.AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .cfg_fwft(cfg_fwft), .cfg_sync(cfg_sync), .cfg_ld(cfg_ld), .cfg_fsel(cfg_fsel),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_wdata(ofs_wdata),
    .ofs_rsel(ofs_rsel), .ofs_rdata(ofs_rdata),
    .pae_n(pae_n), .paf_n(paf_n));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code_dflt(input int c);
    int v;
    case (c)
      4: v = 1023; 2: v = 511; 1: v = 255; 0: v = 127;
      3: v = 63;   6: v = 31;  5: v = 15;  default: v = 7;
    endcase
    return (v > D - 1) ? D - 1 : v;
  endfunction

  task automatic do_reset(input logic fw, input logic sy, input logic ld, input logic [1:0] fs);
    rst_n = 1'b0;
    cfg_fwft = fw; cfg_sync = sy; cfg_ld = ld; cfg_fsel = fs;
    wr_ptr = '0; rd_ptr = '0; ofs_we = 1'b0;
    repeat (6) @(negedge wclk);
    rst_n = 1'b1;
    repeat (6) @(negedge wclk);
  endtask

  task automatic settle();
    repeat (16) @(negedge wclk);
  endtask

  task automatic wr(input int k);
    @(negedge wclk) wr_ptr = wr_ptr + PW'(k);
  endtask

  task automatic rd(input int k);
    @(negedge rclk) rd_ptr = rd_ptr + PW'(k);
  endtask

  task automatic set_ofs(input logic sel, input int val);
    @(negedge wclk);
    ofs_we = 1'b1; ofs_sel = sel; ofs_wdata = (AW+1)'(val);
    @(negedge wclk);
    ofs_we = 1'b0;
  endtask

  task automatic get_ofs(input logic sel, output int v);
    ofs_rsel = sel;
    #1;
    v = int'(ofs_rdata);
  endtask

  task automatic t_defaults();
    int v;
    for (int c = 0; c < 8; c++) begin
      do_reset(1'b0, 1'b1, c[2], c[1:0]);
      get_ofs(1'b0, v); check($sformatf("R1 R2 empty default code %0d", c), v, code_dflt(c));
      get_ofs(1'b1, v); check($sformatf("R1 R2 full default code %0d", c), v, code_dflt(c));
      check("R10 pae_n after reset", pae_n, 0);
      check("R10 paf_n after reset", paf_n, 1);
    end
  endtask

  task automatic t_std();
    int v;
    do_reset(1'b0, 1'b1, 1'b0, 2'b00);
    set_ofs(1'b1, 100);
    get_ofs(1'b1, v); check("R3 full offset saturates", v, D - 1);
    set_ofs(1'b0, 5);
    set_ofs(1'b1, 10);
    get_ofs(1'b0, v); check("R3 empty offset written", v, 5);
    get_ofs(1'b1, v); check("R3 full offset written", v, 10);
    for (int i = 0; i < 7; i++) begin
      wr(32); settle(); rd(32); settle();
    end
    wr(5); settle();  check("R5 count n keeps pae low", pae_n, 0);
    wr(1); settle();  check("R5 count n+1 raises pae", pae_n, 1);
    wr(30); settle(); check("R5 pae across pointer wrap", pae_n, 1);
    check("R7 paf high across pointer wrap", paf_n, 1);
    wr(17); settle(); check("R7 count D-m-1 paf high", paf_n, 1);
    wr(1); settle();  check("R7 count D-m paf low", paf_n, 0);
    rd(1); settle();  check("R7 read below D-m paf high", paf_n, 1);
    rd(48); settle(); check("R5 back to n pae low", pae_n, 0);
  endtask

  task automatic t_fwft();
    do_reset(1'b1, 1'b0, 1'b0, 2'b00);
    set_ofs(1'b0, 5);
    set_ofs(1'b1, 10);
    wr(6); settle();  check("R6 count n+1 pae low", pae_n, 0);
    wr(1); settle();  check("R6 count n+2 pae high", pae_n, 1);
    rd(1); settle();  check("R6 back to n+1 pae low", pae_n, 0);
    wr(48); settle(); check("R7 fwft count D-m paf high", paf_n, 1);
    wr(1); settle();  check("R7 fwft count D+1-m paf low", paf_n, 0);
    rd(1); settle();  check("R7 fwft read releases paf", paf_n, 1);
  endtask

  task automatic t_serial();
    int v;
    do_reset(1'b0, 1'b1, 1'b1, 2'b11);
    set_ofs(1'b0, 20);
    set_ofs(1'b1, 3);
    get_ofs(1'b0, v); check("R4 empty offset unchanged", v, 7);
    get_ofs(1'b1, v); check("R4 full offset unchanged", v, 7);
    wr(7); settle();  check("R4 default n used, pae low", pae_n, 0);
    wr(1); settle();  check("R4 default n used, pae high", pae_n, 1);
    wr(49); settle(); check("R4 default m used, paf low", paf_n, 0);
  endtask

  task automatic t_sync_timing();
    do_reset(1'b0, 1'b1, 1'b0, 2'b01);
    set_ofs(1'b0, 3);
    set_ofs(1'b1, 10);
    wr(3); settle();
    wr(1); @(posedge wclk); #1.2;
    check("R8 pae waits for rclk domain", pae_n, 0);
    settle(); check("R8 pae high after sync", pae_n, 1);
    wr(50); settle(); check("R8 paf low at threshold", paf_n, 0);
    rd(1); @(posedge rclk); #1.2;
    check("R8 paf waits for wclk domain", paf_n, 0);
    settle(); check("R8 paf high after sync", paf_n, 1);
  endtask

  task automatic t_async_timing();
    do_reset(1'b0, 1'b0, 1'b0, 2'b00);
    set_ofs(1'b0, 3);
    set_ofs(1'b1, 10);
    wr(3); settle(); check("R9 pae low at n", pae_n, 0);
    wr(1); @(posedge wclk); #1.2;
    check("R9 pae released on wclk edge", pae_n, 1);
    wr(49); settle(); check("R9 paf high below threshold", paf_n, 1);
    wr(1); @(posedge wclk); #1.2;
    check("R9 paf set on wclk edge", paf_n, 0);
    settle();
    rd(1); @(posedge rclk); #1.2;
    check("R9 paf released on rclk edge", paf_n, 1);
    settle();
    rd(49); settle(); check("R9 pae high at n+1", pae_n, 1);
    rd(1); @(posedge rclk); #1.2;
    check("R9 pae set on rclk edge", pae_n, 0);
  endtask

  initial begin
    t_defaults();
    t_std();
    t_fwft();
    t_serial();
    t_sync_timing();
    t_async_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=completed");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule